// File: doc/BRIEF.md
# Eight-Channel Pin Interrupt Controller

This block watches a set of input pins (eight by default) and turns activity on each of them into a per-channel interrupt request. Every channel can be programmed to react to edges or to levels. Two enable registers choose which polarity counts: one covers rising edges or a high level, the other covers falling edges or a low level. Each enable register can be written whole, or changed bit by bit through a dedicated set port and a dedicated clear port, so software never needs a read-modify-write to change one channel.

Independent of the enables, the block records every rising edge and every falling edge it has seen in two capture registers, cleared by writing ones. A pending-status register holds the request of each channel and drives the interrupt outputs directly. Pins pass through a two-flop synchronizer, and edges are found by comparing the synchronized value with its value one cycle earlier.

Each channel's edge-mode pending flag is a two-state machine. In state ST_QUIET the channel has no edge request. The transition QUIET_TO_HELD fires on an enabled edge while the channel is in edge mode. In state ST_HELD the request is latched. The transition HELD_TO_QUIET fires when software clears the flag in a cycle with no new enabled edge, or when the channel is put into level mode. In level mode the pending output follows the pin and the enables, not the state machine.

Top module: `pinint_ctrl`

## Requirements
- R1: Channel n uses bit n of every register. Read data bits 31:8 are always zero. Word addresses 10 to 15 read as zero, and writes to them change nothing.
- R2: `reg_addr` is a word index, and it selects these registers. 0 is mode. 1 is the high/rise enable. 2 sets high enables and 3 clears them. 4 is the low/fall enable. 5 sets low enables and 6 clears them. 7 is the rise capture, 8 is the fall capture and 9 is pending status. `reg_rdata` shows the selected word while `reg_rd` is 1 and is zero otherwise. A write is taken at the clock edge where `reg_wr` is 1.
- R3: Writing to a set port (2 or 5) ORs the one bits of the data into that enable register. Writing to a clear port (3 or 6) clears the enable bits where the data is 1. Zero bits have no effect. Reading a set or clear port returns the enable register it modifies.
- R4: A mode bit of 0 makes the channel edge sensitive, and 1 makes it level sensitive. A write to address 0, 1 or 4 loads data bits 7:0 into that register.
- R5: A rising edge sets the channel's rise-capture bit, and a falling edge sets its fall-capture bit, whatever the enables are. Writing 1 to a capture bit clears it. An edge in the same cycle as that clear wins, and the bit stays set.
- R6: In edge mode, a rising edge with the high enable set, or a falling edge with the low enable set, makes the channel pending. The flag stays set until a 1 is written to its bit at address 9. A new enabled edge in the same cycle as that clear wins.
- R7: In level mode, the pending bit is 1 exactly while the pin is high with the high enable set, or low with the low enable set. Writes to address 9 do not affect it. Putting a channel into level mode drops any latched edge request, so a channel that returns to edge mode starts not pending.
- R8: `irq_o` equals the pending-status register at all times.
- R9: After a pin change at the input, a level-mode pending bit follows it after the second rising clock edge. Edge-capture bits and edge-mode pending bits are set at the third rising clock edge.
- R10: Reset clears every register: all channels are edge sensitive, disabled, uncaptured and not pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_CH | Asynchronous pin inputs, one per channel |
| reg_addr | input | 4 | Word index of the register being accessed |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, enables `reg_rdata` |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, zero when `reg_rd` is low |
| irq_o | output | NUM_CH | Per-channel interrupt requests |

## Verification
The embedded properties assume that `reg_wr`, `reg_rd` and `reg_addr` carry known values at every rising edge and that at most one register access happens per cycle. They place no rule on how often pins toggle. The stimulus changes strobes, addresses and pins only on the falling clock edge. Between pin changes it leaves four cycles so the synchronizer and edge detector settle before register traffic. The exception is the directed cases that deliberately line a clear write up with the cycle in which a new edge is detected.

// File: rtl/pinint_pkg.sv
`timescale 1ns/1ps
package pinint_pkg;

    localparam int unsigned REG_AW = 4;

    typedef enum logic [REG_AW-1:0] {
        SEL_MODE  = 4'd0,
        SEL_HIEN  = 4'd1,
        SEL_HISET = 4'd2,
        SEL_HICLR = 4'd3,
        SEL_LOEN  = 4'd4,
        SEL_LOSET = 4'd5,
        SEL_LOCLR = 4'd6,
        SEL_RISE  = 4'd7,
        SEL_FALL  = 4'd8,
        SEL_PEND  = 4'd9
    } reg_sel_e;

    typedef enum logic {
        ST_QUIET = 1'b0,
        ST_HELD  = 1'b1
    } chan_state_e;

endpackage

// File: rtl/pinint_sync.sv
`timescale 1ns/1ps
module pinint_sync #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= async_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;

endmodule

// File: rtl/pinint_regif.sv
`timescale 1ns/1ps
module pinint_regif import pinint_pkg::*; #(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [NUM_CH-1:0] mode_v,
    input  logic [NUM_CH-1:0] hien_v,
    input  logic [NUM_CH-1:0] loen_v,
    input  logic [NUM_CH-1:0] rise_v,
    input  logic [NUM_CH-1:0] fall_v,
    input  logic [NUM_CH-1:0] pend_v,
    output logic              mode_we,
    output logic              hien_we,
    output logic              loen_we,
    output logic [NUM_CH-1:0] wbits,
    output logic [NUM_CH-1:0] hi_set,
    output logic [NUM_CH-1:0] hi_clr,
    output logic [NUM_CH-1:0] lo_set,
    output logic [NUM_CH-1:0] lo_clr,
    output logic [NUM_CH-1:0] rise_clr,
    output logic [NUM_CH-1:0] fall_clr,
    output logic [NUM_CH-1:0] pend_clr,
    output logic [DATA_W-1:0] reg_rdata
);

    localparam int unsigned PAD_W = DATA_W - NUM_CH;

    reg_sel_e          sel;
    logic [NUM_CH-1:0] rd_word;
    logic              unused_wdata_hi;

    assign sel             = reg_sel_e'(reg_addr);
    assign wbits           = reg_wdata[NUM_CH-1:0];
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_CH];

    // write strobe decode
    always_comb begin
        mode_we  = 1'b0;
        hien_we  = 1'b0;
        loen_we  = 1'b0;
        hi_set   = '0;
        hi_clr   = '0;
        lo_set   = '0;
        lo_clr   = '0;
        rise_clr = '0;
        fall_clr = '0;
        pend_clr = '0;
        if (reg_wr) begin
            unique case (sel)
                SEL_MODE:  mode_we  = 1'b1;
                SEL_HIEN:  hien_we  = 1'b1;
                SEL_HISET: hi_set   = wbits;
                SEL_HICLR: hi_clr   = wbits;
                SEL_LOEN:  loen_we  = 1'b1;
                SEL_LOSET: lo_set   = wbits;
                SEL_LOCLR: lo_clr   = wbits;
                SEL_RISE:  rise_clr = wbits;
                SEL_FALL:  fall_clr = wbits;
                SEL_PEND:  pend_clr = wbits;
                default:   ;
            endcase
        end
    end

    // read selection
    always_comb begin
        unique case (sel)
            SEL_MODE:                       rd_word = mode_v;
            SEL_HIEN, SEL_HISET, SEL_HICLR: rd_word = hien_v;
            SEL_LOEN, SEL_LOSET, SEL_LOCLR: rd_word = loen_v;
            SEL_RISE:                       rd_word = rise_v;
            SEL_FALL:                       rd_word = fall_v;
            SEL_PEND:                       rd_word = pend_v;
            default:                        rd_word = '0;
        endcase
    end

    assign reg_rdata = reg_rd ? {{PAD_W{1'b0}}, rd_word} : '0;

endmodule

// File: rtl/pinint_chan.sv
`timescale 1ns/1ps
module pinint_chan import pinint_pkg::*; (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic mode_we,
    input  logic hien_we,
    input  logic loen_we,
    input  logic wbit,
    input  logic hi_set,
    input  logic hi_clr,
    input  logic lo_set,
    input  logic lo_clr,
    input  logic rise_clr,
    input  logic fall_clr,
    input  logic pend_clr,
    output logic mode_q,
    output logic hien_q,
    output logic loen_q,
    output logic rise_q,
    output logic fall_q,
    output logic pend_o
);

    chan_state_e state_q;
    chan_state_e state_d;
    logic        prev_q;
    logic        rise_evt;
    logic        fall_evt;
    logic        edge_hit;
    logic        lvl_hit;

    assign rise_evt = pin_s & ~prev_q;
    assign fall_evt = ~pin_s & prev_q;
    assign edge_hit = (rise_evt & hien_q) | (fall_evt & loen_q);
    assign lvl_hit  = (pin_s & hien_q) | (~pin_s & loen_q);

    // configuration and capture registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            mode_q <= 1'b0;
            hien_q <= 1'b0;
            loen_q <= 1'b0;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            prev_q <= pin_s;
            if (mode_we) mode_q <= wbit;
            if (hien_we)     hien_q <= wbit;
            else if (hi_set) hien_q <= 1'b1;
            else if (hi_clr) hien_q <= 1'b0;
            if (loen_we)     loen_q <= wbit;
            else if (lo_set) loen_q <= 1'b1;
            else if (lo_clr) loen_q <= 1'b0;
            rise_q <= rise_evt | (rise_q & ~rise_clr);
            fall_q <= fall_evt | (fall_q & ~fall_clr);
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: if (!mode_q && edge_hit) state_d = ST_HELD;
            ST_HELD: begin
                if (mode_q)                      state_d = ST_QUIET;
                else if (pend_clr && !edge_hit)  state_d = ST_QUIET;
            end
            default: state_d = ST_QUIET;
        endcase
    end

    // outputs
    always_comb begin
        if (mode_q) pend_o = lvl_hit;
        else        pend_o = (state_q == ST_HELD);
    end

    AST_HIEN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_set && !hien_we) |=> hien_q); // R3
    AST_LOEN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_clr && !lo_set && !loen_we) |=> !loen_q); // R3
    AST_RISE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_evt |=> rise_q); // R5
    AST_FALL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_evt |=> fall_q); // R5
    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && !mode_we && pend_o && !pend_clr) |=> pend_o); // R6
    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && !mode_we && edge_hit) |=> pend_o); // R6

endmodule

// File: rtl/pinint_ctrl.sv
`timescale 1ns/1ps
module pinint_ctrl import pinint_pkg::*; #(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pin_i,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NUM_CH-1:0] irq_o
);

    logic [NUM_CH-1:0] pin_s;
    logic [NUM_CH-1:0] mode_v, hien_v, loen_v, rise_v, fall_v, pend_v;
    logic [NUM_CH-1:0] wbits, hi_set, hi_clr, lo_set, lo_clr;
    logic [NUM_CH-1:0] rise_clr, fall_clr, pend_clr;
    logic              mode_we, hien_we, loen_we;

    pinint_sync #(.WIDTH(NUM_CH)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_s)
    );

    pinint_regif #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) regif_i (
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .mode_v    (mode_v),
        .hien_v    (hien_v),
        .loen_v    (loen_v),
        .rise_v    (rise_v),
        .fall_v    (fall_v),
        .pend_v    (pend_v),
        .mode_we   (mode_we),
        .hien_we   (hien_we),
        .loen_we   (loen_we),
        .wbits     (wbits),
        .hi_set    (hi_set),
        .hi_clr    (hi_clr),
        .lo_set    (lo_set),
        .lo_clr    (lo_clr),
        .rise_clr  (rise_clr),
        .fall_clr  (fall_clr),
        .pend_clr  (pend_clr),
        .reg_rdata (reg_rdata)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        pinint_chan chan_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_s    (pin_s[ch]),
            .mode_we  (mode_we),
            .hien_we  (hien_we),
            .loen_we  (loen_we),
            .wbit     (wbits[ch]),
            .hi_set   (hi_set[ch]),
            .hi_clr   (hi_clr[ch]),
            .lo_set   (lo_set[ch]),
            .lo_clr   (lo_clr[ch]),
            .rise_clr (rise_clr[ch]),
            .fall_clr (fall_clr[ch]),
            .pend_clr (pend_clr[ch]),
            .mode_q   (mode_v[ch]),
            .hien_q   (hien_v[ch]),
            .loen_q   (loen_v[ch]),
            .rise_q   (rise_v[ch]),
            .fall_q   (fall_v[ch]),
            .pend_o   (pend_v[ch])
        );
    end

    assign irq_o = pend_v;

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |-> (reg_rdata == '0)); // R2

endmodule

// File: tb/pinint_ctrl_tb.sv
`timescale 1ns/1ps
module pinint_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_i = '0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [7:0] m_mode, m_hien, m_loen, m_rise, m_fall, m_pedge, m_pin;

    always #10 clk = ~clk;

    pinint_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    function automatic logic [7:0] exp_status();
        return (m_pedge & ~m_mode) | (m_mode & ((m_pin & m_hien) | (~m_pin & m_loen)));
    endfunction

    function automatic logic [31:0] exp_read(input int a);
        case (a)
            0:       return {24'h0, m_mode};
            1, 2, 3: return {24'h0, m_hien};
            4, 5, 6: return {24'h0, m_loen};
            7:       return {24'h0, m_rise};
            8:       return {24'h0, m_fall};
            9:       return {24'h0, exp_status()};
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_write(input int a, input logic [31:0] d);
        logic [7:0] b = d[7:0];
        case (a)
            0: m_mode = b;
            1: m_hien = b;
            2: m_hien = m_hien | b;
            3: m_hien = m_hien & ~b;
            4: m_loen = b;
            5: m_loen = m_loen | b;
            6: m_loen = m_loen & ~b;
            7: m_rise = m_rise & ~b;
            8: m_fall = m_fall & ~b;
            9: m_pedge = m_pedge & ~b;
            default: ;
        endcase
        m_pedge = m_pedge & ~m_mode;
    endtask

    task automatic model_pins(input logic [7:0] p);
        logic [7:0] r = p & ~m_pin;
        logic [7:0] f = ~p & m_pin;
        m_rise  = m_rise | r;
        m_fall  = m_fall | f;
        m_pedge = (m_pedge | ((r & m_hien) | (f & m_loen))) & ~m_mode;
        m_pin   = p;
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic do_write(input logic [3:0] a, input logic [31:0] d);
        bus_write(a, d);
        model_write(int'(a), d);
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #2;
        d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic read_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        chk(tag, d, exp);
    endtask

    task automatic drive_pins(input logic [7:0] p);
        @(negedge clk);
        pin_i = p;
        model_pins(p);
        repeat (4) @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        for (int a = 0; a < 10; a++) read_chk(tag, 4'(a), exp_read(a));
        read_chk("R1 unmapped", 4'(10 + ($urandom % 6)), 32'h0);
        #1;
        chk("R8 irq", {24'h0, irq_o}, {24'h0, exp_status()});
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5A17));
        {m_mode, m_hien, m_loen, m_rise, m_fall, m_pedge, m_pin} = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R10 reset state
        check_all("R10 reset");

        // R3 set and clear ports
        do_write(2, 32'h0000_00A5);
        read_chk("R3 set ORs", 1, 32'hA5);
        read_chk("R3 set port reads enable", 2, 32'hA5);
        do_write(3, 32'h0000_0021);
        read_chk("R3 clear", 1, 32'h84);
        do_write(2, 32'h0);
        read_chk("R3 zero no effect", 1, 32'h84);
        do_write(5, 32'hFFFF_FF3C);
        read_chk("R1 upper ignored", 4, 32'h3C);
        do_write(6, 32'h0000_000C);
        read_chk("R3 low clear", 6, 32'h30);

        // R4 whole-word writes
        do_write(0, 32'hFFFF_FF0F);
        read_chk("R4 mode", 0, 32'h0F);
        do_write(1, 32'h1234_5678);
        read_chk("R4 enable load", 1, 32'h78);
        do_write(0, 0); do_write(1, 0); do_write(4, 0);

        // R9 latency: ch0 level, ch1 edge, both high enabled
        do_write(0, 32'h1);
        do_write(2, 32'h3);
        @(negedge clk);
        pin_i = 8'h03;
        model_pins(8'h03);
        @(negedge clk); chk("R9 after 1 edge", {24'h0, irq_o}, 32'h0);
        @(negedge clk); chk("R9 level after 2 edges", {24'h0, irq_o}, 32'h1);
        @(negedge clk); chk("R9 edge after 3 edges", {24'h0, irq_o}, 32'h3);
        check_all("R9");

        // R7 level clear ignored, R6 edge clear works
        do_write(9, 32'h3);
        read_chk("R7 level ignores clear", 9, 32'h1);
        drive_pins(8'h00);
        read_chk("R7 level follows pin", 9, 32'h0);

        // R5 captures
        read_chk("R5 rise capture", 7, 32'h03);
        read_chk("R5 fall capture", 8, 32'h03);
        drive_pins(8'h04);
        read_chk("R5 capture without enable", 7, 32'h07);
        read_chk("R5 no pend without enable", 9, 32'h0);
        do_write(7, 32'h1);
        read_chk("R5 w1c rise", 7, 32'h06);
        do_write(8, 32'h3);
        read_chk("R5 w1c fall", 8, 32'h00);

        // R6 sticky edge pending
        drive_pins(8'h06);
        read_chk("R6 edge sets pending", 9, 32'h02);
        drive_pins(8'h04);
        read_chk("R6 pending sticky", 9, 32'h02);
        do_write(9, 32'h2);
        read_chk("R6 w1c pending", 9, 32'h00);
        do_write(7, 32'h2);

        // R6 and R5: new edge beats same-cycle clear
        @(negedge clk);
        pin_i = 8'h06;
        model_pins(8'h06);
        @(posedge clk);
        @(posedge clk);
        bus_write(9, 32'h2);
        read_chk("R6 edge beats clear", 9, 32'h02);
        drive_pins(8'h04);
        do_write(7, 32'h2);
        @(negedge clk);
        pin_i = 8'h06;
        model_pins(8'h06);
        @(posedge clk);
        @(posedge clk);
        bus_write(7, 32'h2);
        read_chk("R5 edge beats clear", 7, 32'h06);
        check_all("R5 R6");

        // R7 mode switch drops held request
        do_write(0, 32'h3);
        read_chk("R7 level high", 9, 32'h02);
        drive_pins(8'h04);
        read_chk("R7 level low", 9, 32'h00);
        do_write(0, 32'h1);
        read_chk("R7 back to edge not pending", 9, 32'h00);

        // R1 unmapped write ignored
        do_write(13, 32'hFFFF_FFFF);
        check_all("R1 unmapped write");

        // constrained random
        for (int i = 0; i < 300; i++) begin
            int unsigned op = $urandom % 8;
            if (op < 3) drive_pins(8'($urandom));
            else do_write(4'($urandom % 16), $urandom);
            check_all("R2 random");
        end

        finish_run();
    end

endmodule